// File: doc/BRIEF.md
# Dual-Bank 48-Line Parallel I/O Controller

This block is a byte-wide, I/O-mapped controller for 48 digital lines. The lines form two identical banks. Each bank has three 8-bit ports (A, B, C) and one control register. A host moves bytes through a 4-bit offset, a write strobe and a read strobe. Each bank's control register sets line directions. Ports A and B switch as whole bytes. Port C switches as two independent nibbles. Each line drives a latched output value together with an output-enable, which gives a tri-state pad.

Bit 3 of port C in each bank is an interrupt source: line 19 in bank 0 and line 43 in bank 1. A rising edge on either source sets a sticky pending flag, and that flag drives the interrupt output. Three accesses to fixed offsets control the interrupt. The data value of these accesses is ignored. A write to 0xB enables interrupts, a read of 0xB disables them, and a write to 0xF clears anything pending.

Top module: `dual_pio_ctrl`

## Requirements
- R1: After reset every line is an input (pin_oe_o all 0), pin_o is all 0, irq_o is 0 and interrupts are disabled.
- R2: Offsets 0, 1 and 2 write the port A, B and C output latches of bank 0. Offsets 4, 5 and 6 do the same for bank 1. Line number = bank*24 + port*8 + bit, where port A=0, B=1, C=2. pin_o carries the latch value on every line, whatever the direction.
- R3: A control write (offset 3 for bank 0, offset 7 for bank 1) with bit 7 = 1 is a mode word. In it, bit 4 sets the port A direction, bit 1 sets port B, bit 0 sets port C bits 3:0 and bit 3 sets port C bits 7:4. A value of 1 means input. pin_oe_o is 1 exactly on the output lines. The other bank is unaffected.
- R4: A mode word clears all output latches of its own bank to 0 and leaves the other bank's latches unchanged.
- R5: A control write with bit 7 = 0 sets port C bit wdata_i[3:1] of that bank to wdata_i[0]. It leaves the other latch bits and all directions unchanged.
- R6: A port read returns the pin level for input bits and the latch for output bits. The pin level passes through two flops, so a pin change shows in reads after the second rising clock edge following it, and not after the first.
- R7: A write of any value to offset 0xB enables interrupts. A read pulse (rd_i) at offset 0xB disables them.
- R8: While interrupts are enabled, a rising edge on synchronized line 19 or 43 sets a pending flag. irq_o goes high after the third rising clock edge following the pin change, and stays high after the pin falls.
- R9: A write of any value to offset 0xF clears all pending flags. irq_o is low after that clock edge.
- R10: These never set a pending flag, either at the time or later when interrupts are enabled: rising edges while interrupts are disabled, falling edges, and edges on any other line.
- R11: Reads of control offsets 3 and 7 and of offsets 8 to 15 return 0. Writes to offsets 8, 9, 0xA, 0xC, 0xD and 0xE change no line output or output-enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| pin_i | input | 48 | Pad input levels |
| pin_o | output | 48 | Pad output values (latches) |
| pin_oe_o | output | 48 | Pad output enables, 1 = drive |
| irq_o | output | 1 | Interrupt request, level, sticky until cleared |

## Verification
A corrupted direction register shows on pin_oe_o right after the control write that loaded it. It also changes port reads, because the wrong bits switch between pin level and latch. A wrong latch shows on pin_o one cycle after the offending write. If the mode word fails to clear the latches, the fault stays visible until the next port write. A fault in the enable or pending state shows as irq_o rising or failing to rise exactly three edges after a pin change, or failing to fall in the cycle after a clear. The bench therefore samples at those exact cycles, not after long waits.

// File: rtl/dual_pio_pkg.sv
package dual_pio_pkg;
  localparam int unsigned NUM_BANKS      = 2;
  localparam int unsigned PORTS_PER_BANK = 3;
  localparam int unsigned CTRL_SLOT      = 3;
  localparam logic [3:0]  IRQ_EN_OFS     = 4'hB;
  localparam logic [3:0]  IRQ_CLR_OFS    = 4'hF;

  // 1 = input
  typedef struct packed {
    logic dir_a;
    logic dir_b;
    logic dir_cl;
    logic dir_ch;
  } bank_dir_t;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import dual_pio_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [PORTS_PER_BANK-1:0]    wr_port_i,
  input  logic                         wr_ctrl_i,
  input  logic [PORT_W-1:0]            wdata_i,
  input  logic [PORTS_PER_BANK*PORT_W-1:0] pin_sync_i,
  input  logic [1:0]                   rd_sel_i,
  output logic [PORTS_PER_BANK*PORT_W-1:0] out_o,
  output logic [PORTS_PER_BANK*PORT_W-1:0] oe_o,
  output logic [PORT_W-1:0]            rd_data_o
);
  localparam int unsigned HALF  = PORT_W / 2;
  localparam int unsigned SEL_W = $clog2(PORT_W);

  bank_dir_t dir_q;
  logic [PORTS_PER_BANK-1:0][PORT_W-1:0] lat_q, dir_v, pin_v, view_v;
  logic [SEL_W-1:0] bit_sel;

  assign bit_sel = wdata_i[SEL_W:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      dir_q <= '{dir_a: 1'b1, dir_b: 1'b1, dir_cl: 1'b1, dir_ch: 1'b1};
    end else if (wr_ctrl_i && wdata_i[7]) begin
      dir_q <= '{dir_a: wdata_i[4], dir_b: wdata_i[1],
                 dir_cl: wdata_i[0], dir_ch: wdata_i[3]};
      lat_q <= '0;
    end else if (wr_ctrl_i) begin
      lat_q[2][bit_sel] <= wdata_i[0];
    end else begin
      for (int p = 0; p < PORTS_PER_BANK; p++) begin
        if (wr_port_i[p]) lat_q[p] <= wdata_i;
      end
    end
  end

  assign dir_v[0] = {PORT_W{dir_q.dir_a}};
  assign dir_v[1] = {PORT_W{dir_q.dir_b}};
  assign dir_v[2] = {{HALF{dir_q.dir_ch}}, {HALF{dir_q.dir_cl}}};

  assign pin_v  = pin_sync_i;
  assign view_v = (dir_v & pin_v) | (~dir_v & lat_q);

  assign out_o     = lat_q;
  assign oe_o      = ~dir_v;
  assign rd_data_o = (rd_sel_i < 2'd3) ? view_v[rd_sel_i] : '0;
endmodule

// File: rtl/pio_irq_unit.sv
module pio_irq_unit #(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               en_set_i,
  input  logic               en_clr_i,
  input  logic               clr_i,
  output logic               irq_o,
  output logic               en_o
);
  logic [NUM_SRC-1:0] prev_q, pend_q, rise;
  logic               en_q;

  assign rise = src_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
      en_q   <= 1'b0;
    end else begin
      prev_q <= src_i;
      if (en_set_i)      en_q <= 1'b1;
      else if (en_clr_i) en_q <= 1'b0;
      // a new edge in the clear cycle survives
      pend_q <= (pend_q & ~{NUM_SRC{clr_i}}) | (rise & {NUM_SRC{en_q}});
    end
  end

  assign irq_o = |pend_q;
  assign en_o  = en_q;
endmodule

// File: rtl/dual_pio_ctrl.sv
module dual_pio_ctrl
  import dual_pio_pkg::*;
#(
  parameter int unsigned PORT_W  = 8,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned IRQ_BIT = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [PORT_W-1:0]   wdata_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [PORT_W-1:0]   rdata_o,
  input  logic [NUM_BANKS*PORTS_PER_BANK*PORT_W-1:0] pin_i,
  output logic [NUM_BANKS*PORTS_PER_BANK*PORT_W-1:0] pin_o,
  output logic [NUM_BANKS*PORTS_PER_BANK*PORT_W-1:0] pin_oe_o,
  output logic                irq_o
);
  localparam int unsigned BANK_LINES = PORTS_PER_BANK * PORT_W;
  localparam int unsigned LINES      = NUM_BANKS * BANK_LINES;
  localparam int unsigned IRQ_LINE   = 2 * PORT_W + IRQ_BIT;

  logic [LINES-1:0] pin_sync;
  logic             in_banks;
  logic             bank_sel;
  logic [1:0]       slot;
  logic [NUM_BANKS-1:0][PORT_W-1:0] bank_rd;
  logic [NUM_BANKS-1:0] irq_src;
  logic             irq_en;

  assign in_banks = (addr_i[ADDR_W-1:3] == '0);
  assign bank_sel = addr_i[2];
  assign slot     = addr_i[1:0];

  pio_sync #(.W(LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [PORTS_PER_BANK-1:0] wr_port;
    logic                      wr_ctrl;
    logic                      hit;

    assign hit     = wr_i && in_banks && (bank_sel == b[0]);
    assign wr_ctrl = hit && (slot == 2'(CTRL_SLOT));
    for (genvar p = 0; p < PORTS_PER_BANK; p++) begin : g_port
      assign wr_port[p] = hit && (slot == 2'(p));
    end

    pio_bank #(.PORT_W(PORT_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_port_i (wr_port),
      .wr_ctrl_i (wr_ctrl),
      .wdata_i   (wdata_i),
      .pin_sync_i(pin_sync[b*BANK_LINES +: BANK_LINES]),
      .rd_sel_i  (slot),
      .out_o     (pin_o[b*BANK_LINES +: BANK_LINES]),
      .oe_o      (pin_oe_o[b*BANK_LINES +: BANK_LINES]),
      .rd_data_o (bank_rd[b])
    );

    assign irq_src[b] = pin_sync[b*BANK_LINES + IRQ_LINE];
  end

  pio_irq_unit #(.NUM_SRC(NUM_BANKS)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (irq_src),
    .en_set_i(wr_i && (addr_i == ADDR_W'(IRQ_EN_OFS))),
    .en_clr_i(rd_i && (addr_i == ADDR_W'(IRQ_EN_OFS))),
    .clr_i   (wr_i && (addr_i == ADDR_W'(IRQ_CLR_OFS))),
    .irq_o   (irq_o),
    .en_o    (irq_en)
  );

  assign rdata_o = in_banks ? bank_rd[bank_sel] : '0;
endmodule

// File: rtl/dual_pio_chk.sv
module dual_pio_chk #(
  parameter int unsigned LINES = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       addr_i,
  input logic [7:0]       wdata_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [LINES-1:0] pin_o,
  input logic [LINES-1:0] pin_oe_o,
  input logic             irq_o,
  input logic             irq_en_i
);
  localparam int unsigned HALF_L = LINES / 2;

  p_port_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'h0) |=> (pin_o[7:0] == $past(wdata_i)));

  p_oe_only_ctrl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (addr_i == 4'h3 || addr_i == 4'h7)) |=> $stable(pin_oe_o));

  p_mode_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'h3 && wdata_i[7]) |=> (pin_o[HALF_L-1:0] == '0));

  p_rd_disable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 4'hB && !wr_i) |=> !irq_en_i);

  p_irq_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_i && addr_i == 4'hF));

  p_irq_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_en_i));
endmodule

bind dual_pio_ctrl dual_pio_chk #(.LINES(LINES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o),
  .irq_o   (irq_o),
  .irq_en_i(irq_en)
);

// File: tb/dual_pio_ctrl_tb_top.sv
module dual_pio_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [47:0] pin_i = '0;
  logic [47:0] pin_o;
  logic [47:0] pin_oe_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dual_pio_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd_pulse(input logic [3:0] a);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  // call at a negedge; no clock edge passes
  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk("R1 oe", 64'(pin_oe_o), 64'h0);
    chk("R1 out", 64'(pin_o), 64'h0);
    chk("R1 irq", 64'(irq_o), 64'h0);
  endtask

  task automatic t_mode;
    wr(4'h3, 8'h80);
    chk("R3 bank0 all out", 64'(pin_oe_o), 64'h0000_00FF_FFFF);
    wr(4'h7, 8'h91);
    chk("R3 bank1 A in Clo in", 64'(pin_oe_o), 64'hF0FF_00FF_FFFF);
  endtask

  task automatic t_ports;
    logic [7:0] d;
    wr(4'h0, 8'hA5);
    wr(4'h1, 8'h3C);
    wr(4'h2, 8'h7E);
    wr(4'h5, 8'h99);
    chk("R2 bank0 latches", 64'(pin_o[23:0]), 64'h7E3CA5);
    chk("R2 bank1 port B", 64'(pin_o[47:24]), 64'h009900);
    peek(4'h1, d);
    chk("R6 out readback", 64'(d), 64'h3C);
    wr(4'h4, 8'h66);
    chk("R2 latch on input port", 64'(pin_o[31:24]), 64'h66);
  endtask

  task automatic t_setreset;
    wr(4'h3, 8'h0C);
    chk("R5 clear bit6", 64'(pin_o[23:16]), 64'h3E);
    wr(4'h3, 8'h01);
    chk("R5 set bit0", 64'(pin_o[23:16]), 64'h3F);
    chk("R5 dirs kept", 64'(pin_oe_o[23:0]), 64'hFFFFFF);
    chk("R5 A B kept", 64'(pin_o[15:0]), 64'h3CA5);
  endtask

  task automatic t_mode_clear;
    wr(4'h3, 8'h80);
    chk("R4 bank0 cleared", 64'(pin_o[23:0]), 64'h0);
    chk("R4 bank1 kept", 64'(pin_o[47:24]), 64'h009966);
  endtask

  task automatic t_input;
    logic [7:0] d;
    @(negedge clk_i);
    pin_i[31:24] = 8'h5A;
    pin_i[47:40] = 8'hF3;
    @(posedge clk_i);
    @(negedge clk_i);
    peek(4'h4, d);
    chk("R6 one edge old", 64'(d), 64'h00);
    @(posedge clk_i);
    @(negedge clk_i);
    peek(4'h4, d);
    chk("R6 two edges new", 64'(d), 64'h5A);
    peek(4'h6, d);
    chk("R6 nibble mix", 64'(d), 64'h03);
    pin_i[47:40] = 8'h00;
    pin_i[31:24] = 8'h00;
    wait_cyc(3);
  endtask

  task automatic t_irq_basic;
    wr(4'hB, 8'h00);
    pin_i[19] = 1'b1;
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R8 not yet", 64'(irq_o), 64'h0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R8 raised", 64'(irq_o), 64'h1);
    pin_i[19] = 1'b0;
    wait_cyc(4);
    chk("R8 sticky", 64'(irq_o), 64'h1);
    wr(4'hF, 8'h5A);
    chk("R9 cleared", 64'(irq_o), 64'h0);
  endtask

  task automatic t_irq_disabled;
    rd_pulse(4'hB);
    pin_i[43] = 1'b1;
    wait_cyc(5);
    chk("R7 read disables", 64'(irq_o), 64'h0);
    wr(4'hB, 8'hFF);
    wait_cyc(4);
    chk("R10 no late edge", 64'(irq_o), 64'h0);
    pin_i[43] = 1'b0;
    wait_cyc(5);
    chk("R10 falling ignored", 64'(irq_o), 64'h0);
    pin_i[43] = 1'b1;
    wait_cyc(4);
    chk("R8 bank1 source", 64'(irq_o), 64'h1);
    wr(4'hF, 8'h00);
    pin_i[43] = 1'b0;
    chk("R9 bank1 cleared", 64'(irq_o), 64'h0);
  endtask

  task automatic t_other_lines;
    pin_i[18] = 1'b1; pin_i[20] = 1'b1; pin_i[11] = 1'b1; pin_i[42] = 1'b1;
    wait_cyc(5);
    chk("R10 other lines", 64'(irq_o), 64'h0);
    pin_i = '0;
    wait_cyc(3);
  endtask

  task automatic t_unused;
    logic [7:0] d;
    logic [47:0] o_before, oe_before;
    o_before = pin_o;
    oe_before = pin_oe_o;
    wr(4'h8, 8'hFF);
    wr(4'h9, 8'hFF);
    wr(4'hA, 8'h80);
    wr(4'hC, 8'hFF);
    wr(4'hD, 8'h80);
    wr(4'hE, 8'hFF);
    chk("R11 out kept", 64'(pin_o), 64'(o_before));
    chk("R11 oe kept", 64'(pin_oe_o), 64'(oe_before));
    peek(4'h3, d);
    chk("R11 ctrl reads 0", 64'(d), 64'h0);
    peek(4'h9, d);
    chk("R11 unused reads 0", 64'(d), 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mode();
    t_ports();
    t_setreset();
    t_mode_clear();
    t_input();
    t_irq_basic();
    t_irq_disabled();
    t_other_lines();
    t_unused();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule